// File: doc/BRIEF.md
# Dual-Field Shared-Memory Slot Scanner

This block decides, on every clock, which of a set of cores (16 by default) may use a single shared memory port. A down counter walks the slots from the top slot index to slot 0. Each slot belongs to one core and holds two owner fields in a small register table beside the scanner. Field A picks the owner on even scans and field B on odd scans. Two scans make one super-cycle, so a core can keep its whole slot, give away half of it, or give away all of it. Several donors may name the same recipient, and that recipient then collects grants from all of them.

A core changes only its own pair of fields. It does this by a plain write or by an XOR write that flips chosen bits of both fields at once. Writes go to a shadow copy and reach the live table only when the counter reloads, so the owners never change in the middle of a scan. The reload value is either a configured top slot or the index of the highest active core. This lets the scan shorten when the upper cores are idle.

Top module: `slot_scanner`

## Requirements
- R1: After reset every field of slot i holds i, the counter shows slot NUM_CORES-1 and phase A, and the grant sequence is plain round robin: 15, 14, ... 0, repeating.
- R2: The slot counter decreases by one on every clock. The clock after slot 0 it reloads, and the phase (scan_phase 0 = field A, 1 = field B) toggles only on that reload.
- R3: grant_id equals field A of the current slot in phase A and field B in phase B. grant_vec is the one-hot decode of grant_id.
- R4: A core whose field A is itself and whose field B names another core gets exactly one grant per 32-clock super-cycle, and the other core gets one extra grant.
- R5: Several donors may name the same recipient. Three full donors give the recipient 8 grants per 16-slot super-cycle, and the donors get none.
- R6: A write from core c (wr_core) changes only slot c's pair. wr_data[IDW-1:0] is field A and wr_data[2*IDW-1:IDW] is field B.
- R7: With wr_xor set, the new pair is the old shadow pair XOR wr_data. Both fields change in the same clock.
- R8: The live table changes only on the clock where the counter reloads. That load includes a write made on the same clock.
- R9: With len_auto set, the reload value is the index of the highest set bit of active_mask. If no bit is set, it is NUM_CORES-1.
- R10: With len_auto clear, the reload value is cfg_top.
- R11: A change of the reload value while the counter is mid-scan does not move the counter. The new value applies at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Table write strobe from a core |
| wr_core | input | IDW | Index of the writing core (selects its own pair only) |
| wr_xor | input | 1 | 1: XOR write, 0: plain write |
| wr_data | input | 2*IDW | {field B, field A} |
| len_auto | input | 1 | 1: reload from highest active core, 0: from cfg_top |
| cfg_top | input | IDW | Configured top slot index |
| active_mask | input | NUM_CORES | One bit per active core |
| slot_idx | output | IDW | Slot being served this clock |
| scan_phase | output | 1 | 0 = field A scan, 1 = field B scan |
| grant_id | output | IDW | Core granted the port this clock |
| grant_vec | output | NUM_CORES | One-hot form of grant_id |

## Verification
The owner choice is tried with the reset identity table, with single half-shares, and with many donors aimed at one recipient. Grant counts over an aligned super-cycle then tell a 50% share from a full donation and from a stale table. Writes placed in the middle of a scan, and XOR writes, show whether updates are held to the reload boundary and kept to the writer's own pair. A random run compares every clock against a bench model. It mixes random writes, active masks, top values and length-mode changes, so it separates auto length from configured length and catches a reload value that is applied too early.

// File: rtl/slot_pkg.sv
package slot_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} slot_phase_e;

  function automatic slot_phase_e flip_phase(slot_phase_e p);
    return (p == PH_A) ? PH_B : PH_A;
  endfunction
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int unsigned NUM_CORES = 16,
  parameter int unsigned IDW = $clog2(NUM_CORES),
  localparam int unsigned PW = 2 * IDW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [IDW-1:0]           wr_core,
  input  logic                     wr_xor,
  input  logic [PW-1:0]            wr_data,
  input  logic                     commit,
  output logic [NUM_CORES*PW-1:0]  live_flat
);
  function automatic logic [PW-1:0] merge_pair(logic [PW-1:0] old_v,
                                               logic [PW-1:0] data,
                                               logic          use_xor);
    return use_xor ? (old_v ^ data) : data;
  endfunction

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    localparam logic [IDW-1:0] SELF = IDW'(g);
    logic [PW-1:0] shadow_q, live_q, shadow_nx;
    logic          own_write;

    assign own_write = wr_valid && (wr_core == SELF);
    assign shadow_nx = own_write ? merge_pair(shadow_q, wr_data, wr_xor) : shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= {SELF, SELF};
        live_q   <= {SELF, SELF};
      end else begin
        shadow_q <= shadow_nx;
        if (commit) live_q <= shadow_nx;
      end
    end

    assign live_flat[g*PW +: PW] = live_q;
  end
endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int unsigned NUM_CORES = 16,
  parameter int unsigned IDW = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 len_auto,
  input  logic [IDW-1:0]       cfg_top,
  input  logic [NUM_CORES-1:0] active_mask,
  output logic [IDW-1:0]       slot_idx,
  output logic                 phase,
  output logic                 reload_evt,
  output logic [IDW-1:0]       reload_val
);
  import slot_pkg::*;

  localparam logic [IDW-1:0] TOP_DEFAULT = IDW'(NUM_CORES - 1);

  function automatic logic [IDW-1:0] highest_active(logic [NUM_CORES-1:0] m);
    logic [IDW-1:0] r;
    logic           found;
    r = TOP_DEFAULT;
    found = 1'b0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (!found && m[i]) begin
        r = IDW'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  logic [IDW-1:0] cnt_q;
  slot_phase_e    ph_q;

  assign reload_evt = (cnt_q == '0);
  assign reload_val = len_auto ? highest_active(active_mask) : cfg_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TOP_DEFAULT;
      ph_q  <= PH_A;
    end else if (reload_evt) begin
      cnt_q <= reload_val;
      ph_q  <= flip_phase(ph_q);
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign slot_idx = cnt_q;
  assign phase    = ph_q;
endmodule

// File: rtl/slot_grant_mux.sv
module slot_grant_mux #(
  parameter int unsigned NUM_CORES = 16,
  parameter int unsigned IDW = $clog2(NUM_CORES),
  localparam int unsigned PW = 2 * IDW
) (
  input  logic [NUM_CORES*PW-1:0] live_flat,
  input  logic [IDW-1:0]          slot_idx,
  input  logic                    phase,
  output logic [IDW-1:0]          grant_id,
  output logic [NUM_CORES-1:0]    grant_vec
);
  logic [PW-1:0] pair;

  assign pair      = live_flat[slot_idx*PW +: PW];
  assign grant_id  = phase ? pair[PW-1:IDW] : pair[IDW-1:0];
  assign grant_vec = NUM_CORES'(1) << grant_id;
endmodule

// File: rtl/slot_scanner.sv
module slot_scanner #(
  parameter int unsigned NUM_CORES = 16,
  parameter int unsigned IDW = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [IDW-1:0]       wr_core,
  input  logic                 wr_xor,
  input  logic [2*IDW-1:0]     wr_data,
  input  logic                 len_auto,
  input  logic [IDW-1:0]       cfg_top,
  input  logic [NUM_CORES-1:0] active_mask,
  output logic [IDW-1:0]       slot_idx,
  output logic                 scan_phase,
  output logic [IDW-1:0]       grant_id,
  output logic [NUM_CORES-1:0] grant_vec
);
  localparam int unsigned PW = 2 * IDW;

  logic                    reload_evt;
  logic [IDW-1:0]          reload_val;
  logic [NUM_CORES*PW-1:0] live_flat;

  slot_counter #(.NUM_CORES(NUM_CORES), .IDW(IDW)) u_counter (
    .clk(clk), .rst_n(rst_n), .len_auto(len_auto), .cfg_top(cfg_top),
    .active_mask(active_mask), .slot_idx(slot_idx), .phase(scan_phase),
    .reload_evt(reload_evt), .reload_val(reload_val)
  );

  slot_table #(.NUM_CORES(NUM_CORES), .IDW(IDW)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_core(wr_core),
    .wr_xor(wr_xor), .wr_data(wr_data), .commit(reload_evt),
    .live_flat(live_flat)
  );

  slot_grant_mux #(.NUM_CORES(NUM_CORES), .IDW(IDW)) u_mux (
    .live_flat(live_flat), .slot_idx(slot_idx), .phase(scan_phase),
    .grant_id(grant_id), .grant_vec(grant_vec)
  );
endmodule

// File: rtl/slot_scanner_chk.sv
module slot_scanner_chk #(
  parameter int unsigned NUM_CORES = 16,
  parameter int unsigned IDW = $clog2(NUM_CORES)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [IDW-1:0]                slot_idx,
  input logic                          scan_phase,
  input logic                          reload_evt,
  input logic [IDW-1:0]                reload_val,
  input logic [IDW-1:0]                grant_id,
  input logic [NUM_CORES-1:0]          grant_vec,
  input logic [NUM_CORES*2*IDW-1:0]    live_flat,
  input logic                          len_auto,
  input logic [NUM_CORES-1:0]          active_mask
);
  logic [NUM_CORES-1:0] mask_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_d <= '0;
    else        mask_d <= active_mask;
  end

  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != '0) |=> (slot_idx == $past(slot_idx) - 1'b1));
  a_r2_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == '0) |=> (scan_phase != $past(scan_phase)));
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != '0) |=> $stable(scan_phase));
  a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(grant_vec) == 1) && grant_vec[grant_id]);
  a_r8_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_evt |=> $stable(live_flat));
  a_r11_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (slot_idx == $past(reload_val)));
  a_r9_auto_top_active: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && len_auto && (active_mask != '0)) |=> mask_d[slot_idx]);
endmodule

bind slot_scanner slot_scanner_chk #(.NUM_CORES(NUM_CORES), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .scan_phase(scan_phase),
  .reload_evt(reload_evt), .reload_val(reload_val), .grant_id(grant_id),
  .grant_vec(grant_vec), .live_flat(live_flat), .len_auto(len_auto),
  .active_mask(active_mask)
);

// File: tb/slot_scanner_bench.sv
module slot_scanner_bench;
  localparam int N = 16;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_xor = 1'b0, len_auto = 1'b0;
  logic [W-1:0] wr_core = '0, cfg_top = 4'd15;
  logic [2*W-1:0] wr_data = '0;
  logic [N-1:0] active_mask = '0;
  logic [W-1:0] slot_idx, grant_id;
  logic scan_phase;
  logic [N-1:0] grant_vec;

  always #10 clk = ~clk;

  slot_scanner u_slot_scanner (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_core(wr_core),
    .wr_xor(wr_xor), .wr_data(wr_data), .len_auto(len_auto), .cfg_top(cfg_top),
    .active_mask(active_mask), .slot_idx(slot_idx), .scan_phase(scan_phase),
    .grant_id(grant_id), .grant_vec(grant_vec)
  );

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // bench model
  logic [7:0] m_sh [N];
  logic [7:0] m_live [N];
  int m_cnt;
  int m_ph;

  function automatic int model_top();
    if (!len_auto) return int'(cfg_top);
    for (int i = N - 1; i >= 0; i--) if (active_mask[i]) return i;
    return N - 1;
  endfunction

  function automatic int model_owner();
    return (m_ph == 1) ? int'(m_live[m_cnt][7:4]) : int'(m_live[m_cnt][3:0]);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_sh[i] = {4'(i), 4'(i)};
      m_live[i] = m_sh[i];
    end
    m_cnt = N - 1;
    m_ph = 0;
  endtask

  task automatic compare();
    check(tag, int'(slot_idx), m_cnt, "slot");
    check(tag, int'(scan_phase), m_ph, "phase");
    check("R3", int'(grant_id), model_owner(), "grant_id");
    check("R3", int'(grant_vec), 1 << model_owner(), "grant_vec");
  endtask

  // inputs set at negedge; one clock; model update; compare at negedge
  task automatic step();
    @(posedge clk);
    if (wr_valid) m_sh[wr_core] = wr_xor ? (m_sh[wr_core] ^ wr_data) : wr_data;
    if (m_cnt == 0) begin
      for (int i = 0; i < N; i++) m_live[i] = m_sh[i];
      m_cnt = model_top();
      m_ph ^= 1;
    end else m_cnt--;
    @(negedge clk);
    wr_valid = 1'b0;
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_valid = 1'b0; len_auto = 1'b0; cfg_top = 4'd15; active_mask = '0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    compare();
  endtask

  task automatic write(int core, int data, bit x);
    wr_valid = 1'b1; wr_core = 4'(core); wr_data = 8'(data); wr_xor = x;
    step();
  endtask

  task automatic align();
    do step(); while (!(slot_idx == 4'd15 && scan_phase == 1'b0));
  endtask

  task automatic count_super(int core, int exp, string req);
    int n = 0;
    for (int k = 0; k < 32; k++) begin
      if (grant_id == 4'(core)) n++;
      step();
    end
    check(req, n, exp, "grants per super-cycle");
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(1234));
    do_reset();
    // R1: identity round robin
    tag = "R1";
    check("R1", int'(slot_idx), 15, "reset slot");
    check("R1", int'(grant_id), 15, "reset grant");
    for (int k = 0; k < 32; k++) begin
      check("R1", int'(grant_id), 15 - (k % 16), "round robin");
      step();
    end
    // R4: half share core 5 -> 9
    do_reset(); tag = "R4";
    write(5, 8'h95, 0);
    align();
    count_super(5, 1, "R4");
    count_super(9, 3, "R4");
    // R5: three donors to 7
    do_reset(); tag = "R5";
    write(1, 8'h77, 0); write(2, 8'h77, 0); write(3, 8'h77, 0);
    align();
    count_super(7, 8, "R5");
    count_super(2, 0, "R5");
    // R6: only writer's pair changes
    do_reset(); tag = "R6";
    write(4, 8'hCC, 0);
    align();
    count_super(4, 0, "R6");
    count_super(3, 2, "R6");
    // R7: xor write flips field B of core 6 to 5
    do_reset(); tag = "R7";
    write(6, 8'h30, 1);
    align();
    count_super(5, 3, "R7");
    write(6, 8'h30, 1);
    align();
    count_super(6, 2, "R7");
    // R8: write mid-scan does not reach slot 0 until reload
    do_reset(); tag = "R8";
    while (slot_idx != 4'd10) step();
    write(0, 8'h77, 0);
    while (slot_idx != 4'd0) step();
    check("R8", int'(grant_id), 0, "slot 0 before reload");
    step();
    while (slot_idx != 4'd0) step();
    check("R8", int'(grant_id), 7, "slot 0 after reload");
    // R10/R11: configured top change mid-scan
    do_reset(); tag = "R11";
    while (slot_idx != 4'd10) step();
    cfg_top = 4'd3;
    step();
    check("R11", int'(slot_idx), 9, "no jump mid-scan");
    while (slot_idx != 4'd0) step();
    step();
    check("R10", int'(slot_idx), 3, "configured reload");
    // R9: auto length
    tag = "R9";
    len_auto = 1'b1; active_mask = 16'h0014;
    while (slot_idx != 4'd0) step();
    step();
    check("R9", int'(slot_idx), 4, "highest active reload");
    active_mask = '0;
    while (slot_idx != 4'd0) step();
    step();
    check("R9", int'(slot_idx), 15, "none active reload");
    // random mix
    tag = "R2";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(3) == 0) begin
        wr_valid = 1'b1; wr_core = 4'($urandom_range(15));
        wr_data = 8'($urandom); wr_xor = 1'($urandom_range(1));
      end
      if ($urandom_range(63) == 0) len_auto = 1'($urandom_range(1));
      if ($urandom_range(31) == 0) active_mask = 16'($urandom);
      if ($urandom_range(31) == 0) cfg_top = 4'($urandom_range(15));
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule